// File: doc/BRIEF.md
# Scanline Counter with Line-Match Interrupt

This block watches read cycles on the video memory bus and works out where each scanline starts without any direct timing signal from the video unit. The video unit fetches the same nametable address three times in a row at the end of every line, so a run of three identical nametable reads (address at or above 0x2000) is counted as one line tick. The first tick in a frame starts the frame and zeroes the line counter. Each later tick compares the current line count with a programmable compare value and, on a match, latches a pending interrupt.

Software writes the compare value and an enable bit. It polls a status byte that reports the pending and in-frame flags, and reading that byte acknowledges the interrupt. A rendering-active input ends the frame when it drops. The frame also ends by itself once the line count runs past the last visible line.

Top module: `scanline_irq`

## Requirements
- R1: A line tick occurs on a read with `vid_rd` high and `vid_addr` >= 0x2000 whose address equals the addresses of the two preceding such reads; reads below 0x2000 neither tick nor disturb that history.
- R2: After reset the history matches no address, so three identical nametable reads are needed before the first tick can occur.
- R3: A tick while not in a frame sets the in-frame flag, sets the line count to 0 and clears the pending flag, all at the same clock edge.
- R4: A tick while in a frame sets the pending flag if the line count before that tick equals the compare value, then increments the count.
- R5: Inside a frame the 8-bit line count stops at 255 and does not wrap to 0.
- R6: `irq` is high exactly when the pending flag and the enable bit are both set, and it follows a control write or a flag change at the same edge.
- R7: A cycle with `rd_stat` high loads `stat_data` at the next edge with bit 7 = pending, bit 6 = in-frame and bits 5..0 = 0, and clears pending, unless a matching tick in the same cycle sets it.
- R8: The in-frame flag clears one edge after `rendering` is low, or one edge after the line count exceeds LAST_LINE (default 241). Ticks are ignored in that cycle.
- R9: A write with `wr_sel` = 0 loads the compare value from `wr_data`; a write with `wr_sel` = 1 loads the enable from `wr_data` bit 7 and ignores bits 6..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_rd | input | 1 | Video bus read strobe, one cycle per read |
| vid_addr | input | 14 | Video bus read address |
| rendering | input | 1 | High while the video unit is rendering |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = compare value, 1 = control |
| wr_data | input | 8 | Register write data |
| rd_stat | input | 1 | Status read strobe; acknowledges the interrupt |
| irq | output | 1 | Registered interrupt request |
| stat_data | output | 8 | Registered status byte from the last status read |

## Verification
The checker enforces on every cycle that `irq` tracks pending AND enable, that a tick only comes from a nametable read, that a frame start zeroes the count and the pending flag, that an acknowledge without a tick clears pending, that the count never wraps inside a frame, and that a low `rendering` always ends the frame. Only the bench scenarios show the arithmetic: which tick number raises the interrupt for each compare value, that pattern reads leave the history intact, and the exact line on which the frame ends. They also show saturation at 255 through a repeated match, and the case where an acknowledge and a matching tick fall in the same cycle.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  typedef enum logic {
    SEL_CMP = 1'b0,
    SEL_CTL = 1'b1
  } reg_sel_e;

  localparam int EN_BIT       = 7;
  localparam int ST_PEND_BIT  = 7;
  localparam int ST_FRAME_BIT = 6;
endpackage

// File: rtl/scanline_nt_watch.sv
module scanline_nt_watch #(
  parameter int             AW      = 14,
  parameter int             RUN     = 3,
  parameter logic [AW-1:0]  NT_BASE = 'h2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  output logic          tick
);
  localparam int HIST = RUN - 1;

  // extra top bit marks an entry as empty; real addresses carry a 0 there
  logic [HIST-1:0][AW:0] hist;
  logic [HIST-1:0]       same;
  logic                  nt_rd;

  assign nt_rd = rd && (addr >= NT_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '1;
    end else if (nt_rd) begin
      hist[0] <= {1'b0, addr};
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
    end
  end

  for (genvar g = 0; g < HIST; g++) begin : g_cmp
    assign same[g] = (hist[g] == {1'b0, addr});
  end

  assign tick = nt_rd && (&same);
endmodule

// File: rtl/scanline_line_ctr.sv
module scanline_line_ctr #(
  parameter int CW        = 8,
  parameter int LAST_LINE = 241
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rendering,
  input  logic [CW-1:0] cmp,
  input  logic          ack,
  output logic          in_frame,
  output logic          pend,
  output logic          pend_nxt,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW:0]   LAST    = (CW+1)'(LAST_LINE);

  logic          frame_q, frame_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          past_last;

  assign past_last = ({1'b0, cnt_q} > LAST);

  always_comb begin
    frame_d = frame_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    if (ack) pend_d = 1'b0;
    if (!rendering || (frame_q && past_last)) begin
      frame_d = 1'b0;
    end else if (tick) begin
      if (!frame_q) begin
        frame_d = 1'b1;
        cnt_d   = '0;
        pend_d  = 1'b0;
      end else begin
        if (cnt_q == cmp) pend_d = 1'b1;
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      frame_q <= frame_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
    end
  end

  assign in_frame = frame_q;
  assign pend     = pend_q;
  assign pend_nxt = pend_d;
  assign cnt      = cnt_q;
endmodule

// File: rtl/scanline_ctl_regs.sv
module scanline_ctl_regs
  import scanline_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_stat,
  input  logic          pend,
  input  logic          in_frame,
  output logic [CW-1:0] cmp,
  output logic          en,
  output logic          en_nxt,
  output logic [DW-1:0] stat_data
);
  reg_sel_e      sel;
  logic [CW-1:0] cmp_q;
  logic          en_q;
  logic [DW-1:0] stat_q, stat_d;

  assign sel    = reg_sel_e'(wr_sel);
  assign en_nxt = (wr_en && sel == SEL_CTL) ? wr_data[EN_BIT] : en_q;

  always_comb begin
    stat_d               = '0;
    stat_d[ST_PEND_BIT]  = pend;
    stat_d[ST_FRAME_BIT] = in_frame;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      stat_q <= '0;
    end else begin
      if (wr_en && sel == SEL_CMP) cmp_q <= wr_data[CW-1:0];
      en_q <= en_nxt;
      if (rd_stat) stat_q <= stat_d;
    end
  end

  assign cmp       = cmp_q;
  assign en        = en_q;
  assign stat_data = stat_q;
endmodule

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int            AW        = 14,
  parameter int            DW        = 8,
  parameter int            CW        = 8,
  parameter int            RUN       = 3,
  parameter int            LAST_LINE = 241,
  parameter logic [AW-1:0] NT_BASE   = 'h2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vid_rd,
  input  logic [AW-1:0] vid_addr,
  input  logic          rendering,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_stat,
  output logic          irq,
  output logic [DW-1:0] stat_data
);
  logic          tick;
  logic          in_frame, pend, pend_nxt;
  logic          en, en_nxt;
  logic [CW-1:0] cmp, cnt;
  logic          irq_q;

  scanline_nt_watch #(.AW(AW), .RUN(RUN), .NT_BASE(NT_BASE)) u_watch (
    .clk(clk), .rst(rst), .rd(vid_rd), .addr(vid_addr), .tick(tick)
  );

  scanline_line_ctr #(.CW(CW), .LAST_LINE(LAST_LINE)) u_ctr (
    .clk(clk), .rst(rst), .tick(tick), .rendering(rendering), .cmp(cmp),
    .ack(rd_stat), .in_frame(in_frame), .pend(pend), .pend_nxt(pend_nxt),
    .cnt(cnt)
  );

  scanline_ctl_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_stat(rd_stat), .pend(pend), .in_frame(in_frame), .cmp(cmp), .en(en),
    .en_nxt(en_nxt), .stat_data(stat_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pend_nxt && en_nxt;
  end

  assign irq = irq_q;
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
  parameter int            AW      = 14,
  parameter int            DW      = 8,
  parameter int            CW      = 8,
  parameter logic [AW-1:0] NT_BASE = 'h2000
) (
  input logic          clk,
  input logic          rst,
  input logic          vid_rd,
  input logic [AW-1:0] vid_addr,
  input logic          rendering,
  input logic          rd_stat,
  input logic          tick,
  input logic          in_frame,
  input logic          pend,
  input logic          en,
  input logic [CW-1:0] cnt,
  input logic          irq,
  input logic [DW-1:0] stat_data
);
  p_tick_src_r1: assert property (@(posedge clk) disable iff (rst)
    tick |-> (vid_rd && vid_addr >= NT_BASE));

  p_frame_start_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !in_frame && rendering) |=> (in_frame && !pend && cnt == '0));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && in_frame && rendering && cnt != '0) |=> (cnt != '0));

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    irq == (pend && en));

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !tick) |=> !pend);

  p_stat_bits_r7: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (stat_data[7] == $past(pend) && stat_data[6] == $past(in_frame)
                 && stat_data[5:0] == '0));

  p_frame_end_r8: assert property (@(posedge clk) disable iff (rst)
    !rendering |=> !in_frame);
endmodule

bind scanline_irq scanline_irq_chk #(.AW(AW), .DW(DW), .CW(CW), .NT_BASE(NT_BASE)) u_chk (
  .clk(clk), .rst(rst), .vid_rd(vid_rd), .vid_addr(vid_addr),
  .rendering(rendering), .rd_stat(rd_stat), .tick(tick), .in_frame(in_frame),
  .pend(pend), .en(en), .cnt(cnt), .irq(irq), .stat_data(stat_data)
);

// File: tb/test_scanline_irq.sv
module test_scanline_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vid_rd = 1'b0;
  logic [13:0] vid_addr = '0;
  logic        rendering = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_stat = 1'b0;
  logic        irq, irq_s;
  logic [7:0]  stat_data, stat_s;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanline_irq i_scanline_irq (
    .clk(clk), .rst(rst), .vid_rd(vid_rd), .vid_addr(vid_addr),
    .rendering(rendering), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_stat(rd_stat), .irq(irq), .stat_data(stat_data)
  );

  // second copy whose frame never ends on the line limit, to reach saturation
  scanline_irq #(.LAST_LINE(255)) i_scanline_irq_sat (
    .clk(clk), .rst(rst), .vid_rd(vid_rd), .vid_addr(vid_addr),
    .rendering(rendering), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_stat(rd_stat), .irq(irq_s), .stat_data(stat_s)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic nt_read(input logic [13:0] a);
    vid_rd = 1'b1; vid_addr = a;
    @(negedge clk);
    vid_rd = 1'b0;
  endtask

  task automatic do_tick();
    nt_read(14'h23C0);
    nt_read(14'h2000);
    nt_read(14'h2000);
    nt_read(14'h2000);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_status();
    rd_stat = 1'b1;
    @(negedge clk);
    rd_stat = 1'b0;
  endtask

  task automatic end_frame();
    rendering = 1'b0;
    @(negedge clk);
    rendering = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 reset irq", {7'd0, irq}, 8'h00);
    rd_status();
    chk("R7 reset status", stat_data, 8'h00);

    // R2: two reads after reset are not enough
    nt_read(14'h2000); nt_read(14'h2000);
    rd_status();
    chk("R2 two reads no tick", stat_data, 8'h00);
    nt_read(14'h2000);
    rd_status();
    chk("R1 third read ticks, R3 frame set", stat_data, 8'h40);

    // R8: rendering low ends the frame
    end_frame();
    rd_status();
    chk("R8 rendering low", stat_data, 8'h00);

    // R1: differing address breaks the run
    nt_read(14'h2400); nt_read(14'h2400); nt_read(14'h2800);
    rd_status();
    chk("R1 mismatch no tick", stat_data, 8'h00);
    // R1: pattern reads are transparent
    nt_read(14'h2C00); nt_read(14'h0100); nt_read(14'h2C00);
    nt_read(14'h0FFF); nt_read(14'h2C00);
    rd_status();
    chk("R1 pattern reads transparent", stat_data, 8'h40);

    // R4/R6/R9 sweep of compare values
    wr(1'b1, 8'h80);
    for (int c = 0; c < 8; c++) begin
      wr(1'b0, 8'(c));
      end_frame();
      do_tick();
      chk("R3 frame start no irq", {7'd0, irq}, 8'h00);
      for (int j = 1; j <= c; j++) begin
        do_tick();
        chk("R4 before match", {7'd0, irq}, 8'h00);
      end
      do_tick();
      chk("R4 on match", {7'd0, irq}, 8'h01);
      if (c == 3) begin
        wr(1'b1, 8'h7F);
        chk("R9 low bits ignored, R6 masked", {7'd0, irq}, 8'h00);
        wr(1'b1, 8'h80);
        chk("R6 re-enabled", {7'd0, irq}, 8'h01);
      end
      rd_status();
      chk("R7 status pending", stat_data, 8'hC0);
      chk("R7 ack clears irq", {7'd0, irq}, 8'h00);
      rd_status();
      chk("R7 second read", stat_data, 8'h40);
    end

    // R7: acknowledge in the same cycle as a matching tick keeps pending
    wr(1'b0, 8'd1);
    end_frame();
    do_tick();
    do_tick();
    nt_read(14'h23C0); nt_read(14'h2000); nt_read(14'h2000);
    vid_rd = 1'b1; vid_addr = 14'h2000; rd_stat = 1'b1;
    @(negedge clk);
    vid_rd = 1'b0; rd_stat = 1'b0;
    chk("R7 tick wins over ack stat", stat_data, 8'h40);
    chk("R7 tick wins over ack irq", {7'd0, irq}, 8'h01);
    rd_status();

    // R8: frame ends after count passes 241
    wr(1'b0, 8'd250);
    end_frame();
    do_tick();
    for (int j = 0; j < 241; j++) do_tick();
    rd_status();
    chk("R8 line 241 still in frame", stat_data, 8'h40);
    do_tick();
    @(negedge clk);
    rd_status();
    chk("R8 past 241 frame ended", stat_data, 8'h00);

    // R5: saturation at 255 repeats the match
    wr(1'b0, 8'd255);
    end_frame();
    do_tick();
    for (int j = 0; j < 255; j++) do_tick();
    chk("R5 count 255 not matched yet", {7'd0, irq_s}, 8'h00);
    do_tick();
    chk("R4 match at 255", {7'd0, irq_s}, 8'h01);
    rd_status();
    chk("R5 status", stat_s, 8'hC0);
    do_tick();
    chk("R5 saturated count matches again", {7'd0, irq_s}, 8'h01);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule